// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block is the data-register side of a test-access port that reaches a small bank of 32-bit registers. An outside instruction decoder asserts `chain_sel` when the register chain is the active data register. The TAP controller drives one-cycle capture, shift and update strobes, and serial data enters on `tdi` and leaves on `tdo`. In that setup the chain is selected by instruction code 0xC with scan-chain number 0. The chain is 40 bits long: a 32-bit data field, a 7-bit register address and a direction bit.

A scan whose direction bit is 1 writes its data field into the addressed register when the update strobe arrives. A scan whose direction bit is 0 only records a read request at update. The value for that request is fetched at the capture of the next scan and shifted out during that scan. Reading therefore takes two scans. The second scan should name address 0, a read-only identification register, so that it does not cause a fresh access. Address 4 is a trace-RAM data port whose read pointer advances on every read. For that reason the block raises a one-cycle read strobe exactly once per request.

The register storage lives outside the block. It is reached through a combinational port made of an address, a write enable, write data, read data and the read strobe.

Top module: `sdr_port`

## Requirements
- R1: After reset `tdo` is 0, `bank_we` and `bank_rd_fx` are 0, and no read is pending, so the first capture loads an all-zero chain.
- R2: The chain holds data in bits 31:0, the address in bits 38:32 and the direction in bit 39. Each shift moves the chain one place toward bit 0 and loads `tdi` into bit 39. `tdo` always shows bit 0, so data bit 0 leaves first.
- R3: An update with direction 1 raises `bank_we` for that cycle only. During that cycle `bank_addr` is the chain address and `bank_wdata` is the chain data field.
- R4: Capture and shift never raise `bank_we`, and a scan that ends without an update writes nothing.
- R5: An update with direction 0 records a read request for its address. The next capture loads that register's value into bits 31:0 and zero into bits 39:32.
- R6: `bank_rd_fx` is high for one cycle at the first capture after a read request, with `bank_addr` equal to the requested address. A later capture that has no new request reloads the same data and raises no strobe.
- R7: Only addresses whose bit is set in `PRESENT_MASK` are populated (by default addresses 0 to 7). Other addresses read as zero, raise no strobe and ignore writes.
- R8: Addresses whose bit is set in `RDONLY_MASK` ignore writes (by default address 0, the identification register).
- R9: While `chain_sel` is low, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_sel | input | 1 | Register chain is the active data register |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| bank_addr | output | ADDR_W | Register address for write or read |
| bank_we | output | 1 | Write enable, one cycle |
| bank_wdata | output | DATA_W | Write data |
| bank_rdata | input | DATA_W | Read data for `bank_addr`, combinational |
| bank_rd_fx | output | 1 | Read access strobe, one cycle |

## Verification
`bank_we` and `bank_rd_fx` are combinational on the strobe cycle. The bench samples them one time unit after it drives the strobes, before the clock edge. `tdo` comes from a register, so its value is due one edge after a capture or shift, and the bench compares it just after that edge against a bit queue held in its model. A read result appears one whole scan after its request. The model keeps a pending-request record, and each scan's shifted-out data is compared with the value fetched at that scan's capture, so that the one-scan lag itself is checked.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_CAPT, OP_SHFT, OP_UPDT} scan_op_e;

  // capture wins over shift, shift over update; nothing when not selected
  function automatic scan_op_e op_decode(logic sel, logic c, logic s, logic u);
    if (!sel) return OP_NONE;
    if (c) return OP_CAPT;
    if (s) return OP_SHFT;
    if (u) return OP_UPDT;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/sdr_chain.sv
module sdr_chain #(
  parameter int CHAIN_W = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sdr_pkg::scan_op_e     op,
  input  logic                  tdi,
  input  logic [CHAIN_W-1:0]    cap_val,
  output logic [CHAIN_W-1:0]    chain_q
);
  import sdr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else begin
      case (op)
        OP_CAPT: chain_q <= cap_val;
        OP_SHFT: chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdr_read_track.sv
module sdr_read_track #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter logic [2**ADDR_W-1:0] PRESENT_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_fire,
  input  logic              upd_is_rd,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              cap_fire,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_pend,
  output logic              fetch_live,
  output logic [DATA_W-1:0] cap_data
);
  function automatic logic is_present(logic [ADDR_W-1:0] a);
    return PRESENT_MASK[a];
  endfunction

  logic              fetch;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] fresh;

  assign fetch      = cap_fire && rd_pend;
  assign fetch_live = fetch && is_present(rd_addr);
  assign fresh      = is_present(rd_addr) ? bank_rdata : '0;
  assign cap_data   = fetch ? fresh : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_addr <= '0;
      hold_q  <= '0;
    end else begin
      if (upd_fire) begin
        rd_pend <= upd_is_rd;
        if (upd_is_rd) rd_addr <= upd_addr;
      end
      if (fetch) begin
        rd_pend <= 1'b0;
        hold_q  <= fresh;
      end
    end
  end
endmodule

// File: rtl/sdr_port.sv
module sdr_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter logic [2**ADDR_W-1:0] PRESENT_MASK = 'hFF,
  parameter logic [2**ADDR_W-1:0] RDONLY_MASK  = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_sel,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bank_addr,
  output logic              bank_we,
  output logic [DATA_W-1:0] bank_wdata,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              bank_rd_fx
);
  import sdr_pkg::*;

  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int DIR_BIT = CHAIN_W - 1;

  function automatic logic is_writable(logic [ADDR_W-1:0] a);
    return PRESENT_MASK[a] && !RDONLY_MASK[a];
  endfunction

  scan_op_e           op;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] cap_val;
  logic [ADDR_W-1:0]  chain_addr;
  logic               chain_dir;
  logic [ADDR_W-1:0]  rd_addr;
  logic               rd_pend;
  logic               fetch_live;
  logic [DATA_W-1:0]  cap_data;
  logic               upd_fire;
  logic               cap_fire;

  assign op         = op_decode(chain_sel, cap_dr, shift_dr, upd_dr);
  assign upd_fire   = (op == OP_UPDT);
  assign cap_fire   = (op == OP_CAPT);
  assign chain_addr = chain_q[DATA_W +: ADDR_W];
  assign chain_dir  = chain_q[DIR_BIT];
  assign cap_val    = {1'b0, {ADDR_W{1'b0}}, cap_data};

  sdr_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .op(op), .tdi(tdi),
    .cap_val(cap_val), .chain_q(chain_q)
  );

  sdr_read_track #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESENT_MASK(PRESENT_MASK)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .upd_fire(upd_fire), .upd_is_rd(!chain_dir), .upd_addr(chain_addr),
    .cap_fire(cap_fire), .bank_rdata(bank_rdata),
    .rd_addr(rd_addr), .rd_pend(rd_pend), .fetch_live(fetch_live), .cap_data(cap_data)
  );

  assign tdo        = chain_q[0];
  assign bank_we    = upd_fire && chain_dir && is_writable(chain_addr);
  assign bank_addr  = upd_fire ? chain_addr : rd_addr;
  assign bank_wdata = chain_q[DATA_W-1:0];
  assign bank_rd_fx = fetch_live;
endmodule

// File: rtl/sdr_port_chk.sv
module sdr_port_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter logic [2**ADDR_W-1:0] PRESENT_MASK = 'hFF,
  parameter logic [2**ADDR_W-1:0] RDONLY_MASK  = 'h01
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       chain_sel,
  input logic                       cap_dr,
  input logic                       shift_dr,
  input logic                       upd_dr,
  input logic                       tdo,
  input logic [ADDR_W-1:0]          bank_addr,
  input logic                       bank_we,
  input logic                       bank_rd_fx,
  input logic                       rd_pend,
  input logic [DATA_W+ADDR_W:0]     chain_q
);
  // R3
  we_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (upd_dr && chain_sel));
  // R4
  no_write_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_dr || shift_dr) |-> !bank_we);
  // R2
  tdo_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_sel && shift_dr && !cap_dr) |=> (tdo == $past(chain_q[1])));
  // R6
  fx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd_fx |=> (!bank_rd_fx && !rd_pend));
  // R6
  fx_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd_fx |-> (cap_dr && chain_sel));
  // R7
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we || bank_rd_fx) |-> PRESENT_MASK[bank_addr]);
  // R8
  rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> !RDONLY_MASK[bank_addr]);
  // R9
  unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_sel |-> (!bank_we && !bank_rd_fx));
endmodule

bind sdr_port sdr_port_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .PRESENT_MASK(PRESENT_MASK), .RDONLY_MASK(RDONLY_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .cap_dr(cap_dr),
  .shift_dr(shift_dr), .upd_dr(upd_dr), .tdo(tdo), .bank_addr(bank_addr),
  .bank_we(bank_we), .bank_rd_fx(bank_rd_fx), .rd_pend(rd_pend), .chain_q(chain_q)
);

// File: tb/tb_sdr_port.sv
module tb_sdr_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_WORD = 32'h1D0F_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_sel = 1'b0, cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [6:0]  bank_addr;
  logic        bank_we;
  logic [31:0] bank_wdata;
  logic [31:0] bank_rdata;
  logic        bank_rd_fx;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_port dut (
    .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .cap_dr(cap_dr),
    .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
    .bank_addr(bank_addr), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata), .bank_rd_fx(bank_rd_fx)
  );

  function automatic logic [31:0] ram_word(int p);
    return 32'hA500_0000 + p * 3;
  endfunction
  function automatic bit present(int a); return a < 8; endfunction
  function automatic bit rdonly(int a);  return a == 0; endfunction

  // behavioural bank seen by the device
  logic [31:0] bk [128];
  int b_ptr = 0;
  always_comb bank_rdata = (bank_addr == 7'd4) ? ram_word(b_ptr) : bk[bank_addr];
  always @(posedge clk) begin
    if (bank_we) bk[bank_addr] <= bank_wdata;
    if (bank_rd_fx && bank_addr == 7'd4) b_ptr <= b_ptr + 1;
  end

  // reference model
  bit          mq[$];
  bit          m_pend = 0;
  int          m_addr = 0;
  logic [31:0] m_hold = '0;
  logic [31:0] em [128];
  int          m_ptr = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int q_addr();
    int a = 0;
    for (int i = 0; i < 7; i++) a |= int'(mq[32+i]) << i;
    return a;
  endfunction
  function automatic logic [31:0] q_data();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) d[i] = mq[i];
    return d;
  endfunction

  // one clock: drive, check combinational strobes, advance model, check tdo
  task automatic step(bit s, bit c, bit sh, bit u, bit t);
    bit e_we = 0, e_fx = 0;
    logic [31:0] w;
    int a;
    chain_sel = s; cap_dr = c; shift_dr = sh; upd_dr = u; tdi = t;
    if (s && !c && !sh && u && mq[39] && present(q_addr()) && !rdonly(q_addr())) e_we = 1;
    if (s && c && m_pend && present(m_addr)) e_fx = 1;
    #1;
    chk(bank_we == e_we, "R3/R4/R8 bank_we", 32'(bank_we), 32'(e_we));
    chk(bank_rd_fx == e_fx, "R6/R7 bank_rd_fx", 32'(bank_rd_fx), 32'(e_fx));
    if (e_we) chk(bank_wdata == q_data() && bank_addr == 7'(q_addr()), "R3 write port",
                  bank_wdata, q_data());
    if (e_fx) chk(bank_addr == 7'(m_addr), "R6 strobe address", 32'(bank_addr), m_addr);
    if (s && c) begin
      if (m_pend) begin
        if (!present(m_addr)) w = '0;
        else if (m_addr == 4) begin w = ram_word(m_ptr); m_ptr++; end
        else w = em[m_addr];
        m_hold = w; m_pend = 0;
      end
      mq.delete();
      for (int i = 0; i < 32; i++) mq.push_back(m_hold[i]);
      for (int i = 0; i < 8; i++) mq.push_back(1'b0);
    end else if (s && sh) begin
      void'(mq.pop_front());
      mq.push_back(t);
    end else if (s && u) begin
      a = q_addr();
      if (mq[39]) begin
        m_pend = 0;
        if (present(a) && !rdonly(a)) em[a] = q_data();
      end else begin
        m_pend = 1; m_addr = a;
      end
    end
    @(posedge clk); #1;
    chk(tdo == mq[0], "R2 tdo bit", 32'(tdo), 32'(mq[0]));
  endtask

  // full scan: capture, 40 shifts of the command, update; returns shifted-out data
  task automatic scan(bit s, bit dir, int addr, logic [31:0] data, output logic [31:0] got);
    logic [39:0] cmd;
    cmd = {dir, 7'(addr), data};
    step(s, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++) begin
      if (i < 32) got[i] = tdo;
      step(s, 0, 1, 0, cmd[i]);
    end
    step(s, 0, 0, 1, 0);
    step(s, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] got, g1, g2;
    for (int i = 0; i < 128; i++) begin
      bk[i] = (i == 0) ? ID_WORD : 32'h0101_0101 * i;
      em[i] = bk[i];
    end
    for (int i = 0; i < 40; i++) mq.push_back(1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(tdo == 1'b0, "R1 tdo after reset", 32'(tdo), 0);
    chk(!bank_we && !bank_rd_fx, "R1 strobes after reset", 32'({bank_we, bank_rd_fx}), 0);
    scan(1, 1, 1, 32'hDEAD_BEEF, got);
    chk(got == 32'h0, "R1 first capture zero", got, 0);
    // R3 writes
    scan(1, 1, 2, 32'h1234_5678, got);
    // R5 pipelined reads
    scan(1, 0, 1, 0, got);
    scan(1, 0, 2, 0, got);
    chk(got == 32'hDEAD_BEEF, "R5 read reg1 one scan later", got, 32'hDEAD_BEEF);
    scan(1, 0, 0, 0, got);
    chk(got == 32'h1234_5678, "R5 read reg2 one scan later", got, 32'h1234_5678);
    scan(1, 0, 0, 0, got);
    chk(got == ID_WORD, "R5 id register", got, ID_WORD);
    // R6 RAM port advances once per request
    scan(1, 0, 4, 0, got);
    scan(1, 0, 4, 0, got);
    chk(got == ram_word(0), "R6 ram word 0", got, ram_word(0));
    scan(1, 0, 0, 0, got);
    chk(got == ram_word(1), "R6 ram word 1", got, ram_word(1));
    scan(1, 0, 4, 0, got);
    scan(1, 0, 0, 0, got);
    chk(got == ram_word(2), "R6 trailing id scan keeps pointer", got, ram_word(2));
    // R6 capture revisited
    scan(1, 0, 3, 0, got);
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin g1[i] = tdo; step(1, 0, 1, 0, 0); end
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin g2[i] = tdo; step(1, 0, 1, 0, 0); end
    chk(g1 == em[3], "R6 first capture data", g1, em[3]);
    chk(g2 == g1, "R6 recapture same data", g2, g1);
    // R7 absent address
    scan(1, 1, 7'h50, 32'hFFFF_0000, got);
    scan(1, 0, 7'h50, 0, got);
    scan(1, 0, 0, 0, got);
    chk(got == 32'h0, "R7 absent reads zero", got, 0);
    // R8 read-only id
    scan(1, 1, 0, 32'h5555_AAAA, got);
    scan(1, 0, 0, 0, got);
    scan(1, 0, 0, 0, got);
    chk(got == ID_WORD, "R8 id unchanged", got, ID_WORD);
    // R4 shift without update
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 0, 1, 0, (i == 39) ? 1'b1 : 1'b0);
    step(1, 0, 0, 0, 0);
    scan(1, 0, 1, 0, got);
    scan(1, 0, 0, 0, got);
    chk(got == 32'hDEAD_BEEF, "R4 no write without update", got, 32'hDEAD_BEEF);
    // R9 unselected
    scan(0, 1, 2, 32'h0BAD_0BAD, got);
    scan(1, 0, 2, 0, got);
    scan(1, 0, 0, 0, got);
    chk(got == 32'h1234_5678, "R9 unselected write ignored", got, 32'h1234_5678);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule